// File: doc/BRIEF.md
# Asynchronous Serial Port with Programmable Line Polarity

The block is a full-duplex start/stop serial port with one byte of buffering in each direction. Software reaches it through a small 16-bit register interface. A 2-bit select picks one of three registers: the data register, the control register (its read returns status), and the bit-clock divider. A frame has one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Each bit lasts sixteen ticks, and one tick lasts (divider + 1) clock cycles.

The transmit and receive line levels can be inverted independently. A break control forces the transmit line to the space level. Parity can be even or odd. Parity, framing and overrun conditions are held in sticky error flags until software clears them with a control bit. A single interrupt output combines the receive and transmit causes, each under its own enable.

The transmitter state machine has the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. TX_IDLE moves to TX_START when the holding buffer is full, and the byte is taken from the buffer at that moment. Each later state ends after sixteen ticks. TX_DATA moves to TX_PARITY when parity is enabled and to TX_STOP when it is not. TX_STOP returns to TX_IDLE.

The receiver state machine has the states RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP and RX_HOLD. RX_IDLE moves to RX_START when it sees a space level on a tick. RX_START checks the line again eight ticks later and either continues to RX_DATA or drops back to RX_IDLE as a false start. RX_DATA samples each bit at its sixteenth tick. RX_STOP delivers the byte. It then goes to RX_IDLE if the stop bit was a mark, or to RX_HOLD if it was a space. RX_HOLD waits until the line returns to mark.

Top module: `async_serial_port`

## Requirements
- R1: After reset the status read is 0x2100 (transmit buffer empty, line input high), the divider reads 0x000F, tx_line is 1 and irq is 0.
- R2: The divider register (select 2) reads back as written. Every bit after the start bit lasts 16*(divider+1) cycles. The frame is a start bit of level 0, then data bits 0 to 7, then the optional parity bit, then a stop bit of level 1 (levels before output inversion).
- R3: Control bit 1 enables parity and control bit 0 selects odd parity. The transmitted parity bit makes the count of ones across data and parity even (bit 0 clear) or odd (bit 0 set).
- R4: Control bit 2 inverts every transmitted level, including the idle level.
- R5: Control bit 3 inverts the received line before it is decoded, so a transmitter with inverted output and a receiver with inverted input still exchange bytes correctly.
- R6: While control bit 14 is set, tx_line holds the space level (0 with no inversion, 1 with inversion) and status bit 14 reads 1.
- R7: Status bit 8 (transmit buffer empty) goes to 0 on the cycle after a data write (select 0), and returns to 1 once the transmitter takes the byte.
- R8: A received byte sets status bit 7 (receive buffer full). A data read with rd_en returns the byte in bits 7:0 and clears bit 7.
- R9: A byte that completes while bit 7 is still set sets status bit 11 (overrun), and the held byte is kept.
- R10: A stop bit received as space sets status bit 10 (framing error). The byte is still delivered.
- R11: A parity mismatch sets status bit 9. Status bit 15 is the OR of bits 9, 10 and 11. Writing control with bit 6 set clears all three.
- R12: Status bits 4:0 mirror control bits 4:0, and status bit 13 shows the synchronized raw receive pin before inversion.
- R13: irq equals (control bit 5 AND status bit 7) OR (control bit 4 AND status bit 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 data, 1 control/status, 2 divider |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; on select 0 it consumes the received byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register (combinational) |
| rx_line | input | 1 | Serial receive pin |
| tx_line | output | 1 | Serial transmit pin |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. The interrupt is never raised without a full receive buffer or an empty transmit buffer. Break always pins the line to the space level. The transmit-empty flag only falls after a data write. The receive-full flag only rises after a completed frame. Overrun only appears while a byte is still held. The tick counter never passes the divider. Only the bench's scenarios can show the rest: bit timing and order on the wire, parity values, loopback with both polarities inverted, injected parity, framing and overrun errors with their clearing, and the status mirror. The bench also compares irq against a model built from its own copy of the enables on every clock.

// File: rtl/asp_pkg.sv
package asp_pkg;
    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_HOLD
    } rx_state_e;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_DIV  = 2'd2;

    localparam int CB_ODD    = 0;
    localparam int CB_PAREN  = 1;
    localparam int CB_TXINV  = 2;
    localparam int CB_RXINV  = 3;
    localparam int CB_TIE    = 4;
    localparam int CB_RIE    = 5;
    localparam int CB_ERRCLR = 6;
    localparam int CB_BREAK  = 14;
endpackage

// File: rtl/asp_tick.sv
module asp_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div);
endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              par_en,
    input  logic              odd,
    output logic              load,
    output logic              line_bit
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);

    tx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              bit_end;

    assign load    = (state_q == TX_IDLE) && buf_full;
    assign bit_end = tick && (cnt_q == CW'(OVS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (load) state_d = TX_START;
            TX_START:  if (bit_end) state_d = TX_DATA;
            TX_DATA:   if (bit_end && idx_q == BW'(DATA_W - 1))
                           state_d = par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) state_d = TX_STOP;
            TX_STOP:   if (bit_end) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != state_d || bit_end)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
            if (load) begin
                shreg_q <= buf_data;
                par_q   <= (^buf_data) ^ odd;
                idx_q   <= '0;
            end else if (state_q == TX_DATA && bit_end) begin
                shreg_q <= shreg_q >> 1;
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START:  line_bit = 1'b0;
            TX_DATA:   line_bit = shreg_q[0];
            TX_PARITY: line_bit = par_q;
            default:   line_bit = 1'b1;
        endcase
    end

    // R2
    tx_idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && !buf_full) |=> line_bit);
endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              par_en,
    input  logic              odd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DATA_W);
    localparam int HALF = OVS / 2;

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              bit_end;

    assign bit_end = tick && (cnt_q == CW'(OVS - 1));
    assign data    = shreg_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !line) state_d = RX_START;
            RX_START:  if (tick && cnt_q == CW'(HALF - 1))
                           state_d = line ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_end && idx_q == BW'(DATA_W - 1))
                           state_d = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_end) state_d = RX_STOP;
            RX_STOP:   if (bit_end) state_d = line ? RX_IDLE : RX_HOLD;
            RX_HOLD:   if (tick && line) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            done    <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= 1'b0;
            if (state_q != state_d || bit_end)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
            unique case (state_q)
                RX_IDLE: idx_q <= '0;
                RX_DATA: if (bit_end) begin
                    shreg_q <= {line, shreg_q[DATA_W-1:1]};
                    idx_q   <= idx_q + 1'b1;
                end
                RX_PARITY: if (bit_end) par_q <= line;
                RX_STOP: if (bit_end) begin
                    done <= 1'b1;
                    ferr <= !line;
                    perr <= par_en && (((^shreg_q) ^ odd) != par_q);
                end
                default: ;
            endcase
        end
    end

    // R10
    rx_hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HOLD && $past(state_q) != RX_HOLD) |-> (done && ferr));
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
    import asp_pkg::*;
#(
    parameter int             DATA_W    = 8,
    parameter int             DIV_W     = 16,
    parameter int             OVS       = 16,
    parameter logic [15:0]    RESET_DIV = 16'h000F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        rx_line,
    output logic        tx_line,
    output logic        irq
);
    localparam int REG_W = 16;

    logic              odd_q, par_en_q, tx_inv_q, rx_inv_q, tie_q, rie_q, brk_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] tx_buf_q, rx_buf_q;
    logic              tbe_q, rbf_q, pe_q, fe_q, oe_q;
    logic [1:0]        sync_q;
    logic              raw_in, rx_in;
    logic              tick, tx_load, tx_bit;
    logic              rx_done, rx_perr, rx_ferr;
    logic [DATA_W-1:0] rx_byte;
    logic              wr_data_sel, wr_ctrl_sel, wr_div_sel, rd_data_sel, err_clr;
    logic [REG_W-1:0]  status;

    assign wr_data_sel = wr_en && reg_sel == SEL_DATA;
    assign wr_ctrl_sel = wr_en && reg_sel == SEL_CTRL;
    assign wr_div_sel  = wr_en && reg_sel == SEL_DIV;
    assign rd_data_sel = rd_en && reg_sel == SEL_DATA;
    assign err_clr     = wr_ctrl_sel && wr_data[CB_ERRCLR];

    assign raw_in = sync_q[1];
    assign rx_in  = raw_in ^ rx_inv_q;

    asp_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(wr_div_sel), .div(div_q), .tick(tick)
    );

    asp_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .buf_full(!tbe_q),
        .buf_data(tx_buf_q), .par_en(par_en_q), .odd(odd_q),
        .load(tx_load), .line_bit(tx_bit)
    );

    asp_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_in),
        .par_en(par_en_q), .odd(odd_q), .done(rx_done), .data(rx_byte),
        .perr(rx_perr), .ferr(rx_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {odd_q, par_en_q, tx_inv_q, rx_inv_q, tie_q, rie_q, brk_q} <= '0;
            div_q    <= DIV_W'(RESET_DIV);
            tx_buf_q <= '0;
            tbe_q    <= 1'b1;
            rx_buf_q <= '0;
            rbf_q    <= 1'b0;
            pe_q     <= 1'b0;
            fe_q     <= 1'b0;
            oe_q     <= 1'b0;
            sync_q   <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rx_line};
            if (wr_ctrl_sel) begin
                odd_q    <= wr_data[CB_ODD];
                par_en_q <= wr_data[CB_PAREN];
                tx_inv_q <= wr_data[CB_TXINV];
                rx_inv_q <= wr_data[CB_RXINV];
                tie_q    <= wr_data[CB_TIE];
                rie_q    <= wr_data[CB_RIE];
                brk_q    <= wr_data[CB_BREAK];
            end
            if (wr_div_sel)
                div_q <= wr_data[DIV_W-1:0];
            if (wr_data_sel) begin
                tx_buf_q <= wr_data[DATA_W-1:0];
                tbe_q    <= 1'b0;
            end else if (tx_load) begin
                tbe_q <= 1'b1;
            end
            if (rx_done && !rbf_q) begin
                rx_buf_q <= rx_byte;
                rbf_q    <= 1'b1;
            end else if (rd_data_sel) begin
                rbf_q <= 1'b0;
            end
            pe_q <= (pe_q && !err_clr) || (rx_done && rx_perr);
            fe_q <= (fe_q && !err_clr) || (rx_done && rx_ferr);
            oe_q <= (oe_q && !err_clr) || (rx_done && rbf_q);
        end
    end

    assign status = {pe_q | fe_q | oe_q, brk_q, raw_in, 1'b0, oe_q, fe_q, pe_q,
                     tbe_q, rbf_q, 2'b00, tie_q, rx_inv_q, tx_inv_q, par_en_q, odd_q};

    always_comb begin
        unique case (reg_sel)
            SEL_DATA: rd_data = REG_W'(rx_buf_q);
            SEL_CTRL: rd_data = status;
            SEL_DIV:  rd_data = REG_W'(div_q);
            default:  rd_data = '0;
        endcase
    end

    assign tx_line = (brk_q ? 1'b0 : tx_bit) ^ tx_inv_q;
    assign irq     = (rie_q && rbf_q) || (tie_q && tbe_q);

    // R6
    brk_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> (tx_line == tx_inv_q));
    // R7
    tbe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tbe_q) |-> $past(wr_en && reg_sel == SEL_DATA));
    // R8
    rbf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rbf_q) |-> $past(rx_done));
    // R9
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(rbf_q && rx_done));
    // R13
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rbf_q || tbe_q));
endmodule

// File: tb/sim_async_serial_port.sv
module sim_async_serial_port;
    localparam int BIT = 16 * (3 + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tx_line, irq;
    logic        loop = 1'b0;
    logic        bb_line = 1'b1;
    logic        rx_line;
    logic        sh_tie = 1'b0, sh_rie = 1'b0;
    int          n_chk = 0, n_fail = 0;

    assign rx_line = loop ? tx_line : bb_line;

    always #5 clk = ~clk;

    async_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .rx_line(rx_line), .tx_line(tx_line),
        .irq(irq)
    );

    function automatic void chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // per-clock reference model of the interrupt output (R13)
    always @(posedge clk) begin
        #3;
        if (rst_n && reg_sel == 2'd1 && !wr_en && !rd_en)
            chk("R13 irq model", {15'd0, irq},
                {15'd0, (sh_rie & rd_data[7]) | (sh_tie & rd_data[8])});
    end

    task automatic reg_wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (s == 2'd1) begin
            sh_tie = d[4];
            sh_rie = d[5];
        end
        @(negedge clk);
        reg_sel = 2'd1;
        #1;
    endtask

    task automatic reg_rd(input logic [1:0] s, input logic clr, output logic [15:0] v);
        @(negedge clk);
        reg_sel = s; rd_en = clr;
        #1 v = rd_data;
        @(posedge clk);
        #1 rd_en = 1'b0;
        @(negedge clk);
        reg_sel = 2'd1;
        #1;
    endtask

    task automatic tx_watch(input logic [7:0] b, input logic pen, input logic pbit,
                            input logic inv);
        int w = 0;
        while (tx_line !== inv && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk("R2 start bit seen", {15'd0, tx_line}, {15'd0, inv});
        repeat (BIT + BIT / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            chk("R2 data bit", {15'd0, tx_line}, {15'd0, b[i] ^ inv});
            repeat (BIT) @(negedge clk);
        end
        if (pen) begin
            chk("R3 parity bit", {15'd0, tx_line}, {15'd0, pbit ^ inv});
            repeat (BIT) @(negedge clk);
        end
        chk("R2 stop bit", {15'd0, tx_line}, {15'd0, ~inv});
    endtask

    task automatic bb_send(input logic [7:0] b, input logic pen, input logic pbit,
                           input logic stopv);
        @(negedge clk);
        bb_line = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            bb_line = b[i];
            repeat (BIT) @(negedge clk);
        end
        if (pen) begin
            bb_line = pbit;
            repeat (BIT) @(negedge clk);
        end
        bb_line = stopv;
        repeat (BIT) @(negedge clk);
        bb_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 status", rd_data, 16'h2100);
        chk("R1 tx_line", {15'd0, tx_line}, 16'd1);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        reg_rd(2'd2, 1'b0, v);
        chk("R1 divider reset", v, 16'h000F);

        // R2 divider readback
        reg_wr(2'd2, 16'h0003);
        reg_rd(2'd2, 1'b0, v);
        chk("R2 divider", v, 16'h0003);

        // R13 transmit interrupt
        reg_wr(2'd1, 16'h0010);
        chk("R13 tx irq on", {15'd0, irq}, 16'd1);
        reg_wr(2'd1, 16'h0000);
        chk("R13 tx irq off", {15'd0, irq}, 16'd0);

        // loopback, no parity, receive interrupt enabled
        loop = 1'b1;
        reg_wr(2'd1, 16'h0020);
        reg_wr(2'd0, 16'h00A5);
        chk("R7 tbe cleared by write", {15'd0, rd_data[8]}, 16'd0);
        tx_watch(8'hA5, 1'b0, 1'b0, 1'b0);
        chk("R7 tbe set after load", {15'd0, rd_data[8]}, 16'd1);
        repeat (BIT) @(negedge clk);
        #1;
        chk("R8 rbf set", {15'd0, rd_data[7]}, 16'd1);
        chk("R13 rx irq", {15'd0, irq}, 16'd1);
        reg_rd(2'd0, 1'b1, v);
        chk("R8 data", v, 16'h00A5);
        chk("R8 rbf cleared", {15'd0, rd_data[7]}, 16'd0);
        chk("R13 rx irq cleared", {15'd0, irq}, 16'd0);

        // R3 even parity
        reg_wr(2'd1, 16'h0002);
        reg_wr(2'd0, 16'h003C);
        tx_watch(8'h3C, 1'b1, 1'b0, 1'b0);
        repeat (BIT) @(negedge clk);
        #1;
        chk("R3 even no perr", {15'd0, rd_data[9]}, 16'd0);
        reg_rd(2'd0, 1'b1, v);
        chk("R3 even data", v, 16'h003C);

        // R3 odd parity
        reg_wr(2'd1, 16'h0003);
        reg_wr(2'd0, 16'h003C);
        tx_watch(8'h3C, 1'b1, 1'b1, 1'b0);
        repeat (BIT) @(negedge clk);
        #1;
        chk("R3 odd no perr", {15'd0, rd_data[9]}, 16'd0);
        reg_rd(2'd0, 1'b1, v);
        chk("R3 odd data", v, 16'h003C);

        // R4 / R5 both polarities inverted
        reg_wr(2'd1, 16'h000C);
        repeat (BIT) @(negedge clk);
        #1;
        chk("R4 inverted idle", {15'd0, tx_line}, 16'd0);
        reg_rd(2'd0, 1'b1, v);
        reg_wr(2'd0, 16'h005A);
        tx_watch(8'h5A, 1'b0, 1'b0, 1'b1);
        repeat (BIT) @(negedge clk);
        #1;
        chk("R5 rbf", {15'd0, rd_data[7]}, 16'd1);
        chk("R5 no ferr", {15'd0, rd_data[10]}, 16'd0);
        reg_rd(2'd0, 1'b1, v);
        chk("R5 data", v, 16'h005A);

        // R11 parity error injected
        loop = 1'b0;
        reg_wr(2'd1, 16'h0042);
        repeat (BIT) @(negedge clk);
        bb_send(8'h01, 1'b1, 1'b0, 1'b1);
        chk("R11 perr", {15'd0, rd_data[9]}, 16'd1);
        chk("R11 summary", {15'd0, rd_data[15]}, 16'd1);
        reg_rd(2'd0, 1'b1, v);
        chk("R11 data kept", v, 16'h0001);
        reg_wr(2'd1, 16'h0040);
        chk("R11 cleared", {4'd0, rd_data[15], 2'd0, rd_data[11:9], 9'd0}, 16'd0);

        // R10 framing error
        bb_send(8'h55, 1'b0, 1'b0, 1'b0);
        chk("R10 ferr", {15'd0, rd_data[10]}, 16'd1);
        chk("R10 summary", {15'd0, rd_data[15]}, 16'd1);
        reg_rd(2'd0, 1'b1, v);
        chk("R10 data", v, 16'h0055);
        reg_wr(2'd1, 16'h0040);
        chk("R10 cleared", {15'd0, rd_data[10]}, 16'd0);

        // R9 overrun
        bb_send(8'h11, 1'b0, 1'b0, 1'b1);
        chk("R9 no oe yet", {15'd0, rd_data[11]}, 16'd0);
        bb_send(8'h22, 1'b0, 1'b0, 1'b1);
        chk("R9 oe", {15'd0, rd_data[11]}, 16'd1);
        chk("R9 summary", {15'd0, rd_data[15]}, 16'd1);
        reg_rd(2'd0, 1'b1, v);
        chk("R9 first byte kept", v, 16'h0011);
        reg_wr(2'd1, 16'h0040);
        chk("R9 cleared", {15'd0, rd_data[11]}, 16'd0);

        // R6 break
        reg_wr(2'd1, 16'h4000);
        chk("R6 break line", {15'd0, tx_line}, 16'd0);
        chk("R6 break status", {15'd0, rd_data[14]}, 16'd1);
        reg_wr(2'd1, 16'h4004);
        chk("R6 break inverted", {15'd0, tx_line}, 16'd1);
        reg_wr(2'd1, 16'h0000);
        chk("R6 break released", {15'd0, tx_line}, 16'd1);

        // R12 mirror and raw input
        reg_wr(2'd1, 16'h001F);
        chk("R12 mirror", {11'd0, rd_data[4:0]}, 16'h001F);
        reg_wr(2'd1, 16'h0000);
        bb_line = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 raw low", {15'd0, rd_data[13]}, 16'd0);
        bb_line = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 raw high", {15'd0, rd_data[13]}, 16'd1);

        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule